// File: doc/BRIEF.md
# Two-Requester Bus Master Port with Sticky Ownership

This block lets a transmit DMA engine and a receive DMA engine share one AHB master port. Each engine hands over a transfer command: start address, transfer size, beat count, and whether the address increments or stays fixed. The block picks one engine and runs that command beat by beat on the bus. It returns read data, asks for write data, and signals the end of the command, with an error flag when the slave reported ERROR.

The command interface is a valid/ready handshake. A requester raises `rq_valid` and must hold its command fields steady until it sees its `rq_ready` bit. `rq_ready` is only offered while no command is running, and at most one bit is high. Write data has no valid bit. The owning requester must present the data for its current beat on its `wd_data` slice and hold it until its `wd_ready` bit pulses; the next beat's data follows after that pulse. Read data cannot be back-pressured: the owner's `rd_valid` bit marks one cycle in which `rd_data` must be taken.

Ownership is sticky. The last engine served keeps ownership and wins again whenever it asks. A beat count of zero is taken as one.

Top module: `ahbm_shared_port`

## Requirements
- R1: When the requester that was served last raises `rq_valid` again, it receives `rq_ready`, even if the other requester is also requesting. At most one `rq_ready` bit is high in any cycle.
- R2: With no previous owner (after reset) and both requesting, the receive requester (index 1) is served. When the owner is not requesting and the other one is, the other one is served.
- R3: HSIZE is 0 (byte), 1 (halfword) or 2 (word). A command size code of 3 is issued as word.
- R4: Every byte or halfword beat is NONSEQ (HTRANS=2). In incrementing mode the address steps by 1 or 2 bytes.
- R5: An incrementing word command issues its first beat as NONSEQ and the following beats as SEQ (HTRANS=3), each 4 bytes above the previous one. Address and size are held while HREADY is low.
- R6: In fixed-address mode every beat uses the start address and is NONSEQ.
- R7: A beat whose address is a multiple of 1024 is never SEQ. An incrementing word burst that reaches such an address restarts there with NONSEQ.
- R8: HTRANS is never BUSY (1).
- R9: On a RETRY (HRESP=2) or SPLIT (HRESP=3) response, the failed beat is reissued at the same address as NONSEQ once the grant is held again. Later beats then follow normally, and every beat completes exactly once.
- R10: On an ERROR response (HRESP=1), HTRANS is IDLE for both response cycles and no further beat of the command is issued. The owner's `xfer_done` bit pulses with `xfer_err` high.
- R11: On each OKAY completion of a read beat, the owner's `rd_valid` bit pulses with `rd_data` equal to HRDATA. On each OKAY completion of a write beat, the owner's `wd_ready` bit pulses while HWDATA carries the owner's `wd_data` slice.
- R12: Completion of the last beat pulses the owner's `xfer_done` bit with `xfer_err` low. From the next cycle, HBUSREQ is low and HTRANS is IDLE until a new command is accepted.
- R13: After reset, HTRANS is IDLE, HBUSREQ is low, and no ready, valid or done bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 2 | Command valid per requester (bit 0 transmit, bit 1 receive) |
| rq_ready | output | 2 | Command accepted, one-hot |
| rq_addr | input | 2*AW | Start address per requester |
| rq_size | input | 4 | Size code per requester (0 byte, 1 halfword, 2 word) |
| rq_beats | input | 2*BW | Beat count per requester |
| rq_incr | input | 2 | 1 incrementing, 0 fixed address |
| rq_write | input | 2 | 1 write, 0 read |
| wd_data | input | 2*DW | Write data per requester for its current beat |
| wd_ready | output | 2 | Write beat consumed by owner |
| rd_data | output | DW | Read data |
| rd_valid | output | 2 | Read beat delivered to owner |
| xfer_done | output | 2 | Command finished, to owner |
| xfer_err | output | 1 | Qualifies xfer_done: slave reported ERROR |
| hgrant | input | 1 | Bus grant |
| hready | input | 1 | Transfer ready |
| hresp | input | 2 | Slave response |
| hrdata | input | DW | Read data bus |
| hbusreq | output | 1 | Bus request |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Address |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Write strobe |
| hwdata | output | DW | Write data bus |

## Verification
The hardest state to reach is a RETRY or SPLIT in the middle of a SEQ burst. The next beat's address is already on the bus at that moment, so the block must withdraw it, rewind by one beat, and, after a SPLIT, wait out a lost grant before resuming with NONSEQ. The bench's slave model injects a chosen response on a chosen beat and withdraws the grant for a few cycles after a SPLIT. The scoreboard holds the expected beat list, including the reissued beat, so a missing, doubled or wrongly typed beat shows up as a mismatch. A burst placed just below a 1 KB line checks the restart at the boundary, and wait states stretch data phases to check that the address is held.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_BUSY = 2'd1,
    TR_NSEQ = 2'd2,
    TR_SEQ  = 2'd3
  } htrans_e;

  localparam logic [1:0] RESP_OKAY  = 2'd0;
  localparam logic [1:0] RESP_ERROR = 2'd1;
  localparam logic [1:0] RESP_RETRY = 2'd2;
  localparam logic [1:0] RESP_SPLIT = 2'd3;

  localparam int NREQ  = 2;
  localparam int TX_ID = 0;
  localparam int RX_ID = 1;
endpackage

// File: rtl/ahbm_sticky_arb.sv
module ahbm_sticky_arb
  import ahbm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            take,
  output logic            win,
  output logic [NREQ-1:0] win_oh
);
  logic owner_q;
  logic have_q;

  // Holder keeps the port when it asks; otherwise the receive side is preferred.
  always_comb begin
    if (have_q && req[owner_q]) win = owner_q;
    else if (req[RX_ID])        win = 1'b1;
    else                        win = 1'b0;
    win_oh = NREQ'(1) << win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      have_q  <= 1'b0;
    end else if (take) begin
      owner_q <= win;
      have_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/ahbm_addr_step.sv
module ahbm_addr_step #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BOUND_LOG2 = 10
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    size,
  input  logic          incr,
  input  logic          restart,
  output logic [AW-1:0] nxt,
  output logic          seq_ok
);
  localparam logic [1:0] WORD_SZ = 2'($clog2(DW / 8));

  logic at_line;

  always_comb begin
    nxt     = incr ? cur + (AW'(1) << size) : cur;
    at_line = (cur[BOUND_LOG2-1:0] == '0);
    seq_ok  = !restart && incr && (size == WORD_SZ) && !at_line;
  end
endmodule

// File: rtl/ahbm_shared_port.sv
module ahbm_shared_port
  import ahbm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BW         = 8,
  parameter int BOUND_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rq_valid,
  output logic [1:0]       rq_ready,
  input  logic [2*AW-1:0]  rq_addr,
  input  logic [3:0]       rq_size,
  input  logic [2*BW-1:0]  rq_beats,
  input  logic [1:0]       rq_incr,
  input  logic [1:0]       rq_write,
  input  logic [2*DW-1:0]  wd_data,
  output logic [1:0]       wd_ready,
  output logic [DW-1:0]    rd_data,
  output logic [1:0]       rd_valid,
  output logic [1:0]       xfer_done,
  output logic             xfer_err,
  input  logic             hgrant,
  input  logic             hready,
  input  logic [1:0]       hresp,
  input  logic [DW-1:0]    hrdata,
  output logic             hbusreq,
  output logic [1:0]       htrans,
  output logic [AW-1:0]    haddr,
  output logic [2:0]       hsize,
  output logic             hwrite,
  output logic [DW-1:0]    hwdata
);
  localparam logic [1:0] WORD_SZ = 2'($clog2(DW / 8));

  logic          busy_q, own_q, incr_q, write_q, dp_q, restart_q;
  logic [AW-1:0] addr_q, dp_addr_q;
  logic [1:0]    size_q;
  logic [BW-1:0] beats_q, a_cnt_q, d_cnt_q;

  logic            take, win, more, issue, seq_ok;
  logic [1:0]      win_oh, own_oh, cmd_size;
  logic [AW-1:0]   nxt_addr, cmd_addr;
  logic [BW-1:0]   cmd_beats;
  logic            dp_ok, dp_bad, last_ok, err_end, rewind;

  assign take = !busy_q && (|rq_valid);

  ahbm_sticky_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (rq_valid),
    .take   (take),
    .win    (win),
    .win_oh (win_oh)
  );

  ahbm_addr_step #(.AW(AW), .DW(DW), .BOUND_LOG2(BOUND_LOG2)) u_step (
    .cur     (addr_q),
    .size    (size_q),
    .incr    (incr_q),
    .restart (restart_q),
    .nxt     (nxt_addr),
    .seq_ok  (seq_ok)
  );

  always_comb begin
    cmd_addr  = rq_addr[win*AW +: AW];
    cmd_size  = rq_size[win*2 +: 2];
    cmd_beats = rq_beats[win*BW +: BW];
    if (cmd_size == 2'd3) cmd_size = WORD_SZ;
    if (cmd_beats == '0)  cmd_beats = BW'(1);
  end

  always_comb begin
    own_oh   = 2'b01 << own_q;
    rq_ready = take ? win_oh : 2'b00;
    more     = busy_q && (a_cnt_q != beats_q);
    issue    = more && hgrant && (hresp == RESP_OKAY);
    htrans   = issue ? (seq_ok ? TR_SEQ : TR_NSEQ) : TR_IDLE;
    haddr    = addr_q;
    hsize    = {1'b0, size_q};
    hwrite   = write_q;
    hbusreq  = more;
    hwdata   = wd_data[own_q*DW +: DW];
    rd_data  = hrdata;
    dp_ok    = dp_q && hready && (hresp == RESP_OKAY);
    dp_bad   = dp_q && hready && (hresp != RESP_OKAY);
    last_ok  = dp_ok && (d_cnt_q + BW'(1) == beats_q);
    err_end  = dp_bad && (hresp == RESP_ERROR);
    rewind   = dp_bad && (hresp != RESP_ERROR);
    rd_valid = (dp_ok && !write_q) ? own_oh : 2'b00;
    wd_ready = (dp_ok &&  write_q) ? own_oh : 2'b00;
    xfer_done = (last_ok || err_end) ? own_oh : 2'b00;
    xfer_err  = err_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      own_q     <= 1'b0;
      incr_q    <= 1'b0;
      write_q   <= 1'b0;
      dp_q      <= 1'b0;
      restart_q <= 1'b1;
      addr_q    <= '0;
      dp_addr_q <= '0;
      size_q    <= '0;
      beats_q   <= '0;
      a_cnt_q   <= '0;
      d_cnt_q   <= '0;
    end else if (take) begin
      busy_q    <= 1'b1;
      own_q     <= win;
      addr_q    <= cmd_addr;
      size_q    <= cmd_size;
      beats_q   <= cmd_beats;
      incr_q    <= rq_incr[win];
      write_q   <= rq_write[win];
      a_cnt_q   <= '0;
      d_cnt_q   <= '0;
      dp_q      <= 1'b0;
      restart_q <= 1'b1;
    end else if (busy_q && hready) begin
      if (last_ok || err_end) begin
        busy_q <= 1'b0;
        dp_q   <= 1'b0;
      end else if (rewind) begin
        addr_q    <= dp_addr_q;
        a_cnt_q   <= d_cnt_q;
        restart_q <= 1'b1;
        dp_q      <= 1'b0;
      end else begin
        if (dp_ok) d_cnt_q <= d_cnt_q + BW'(1);
        if (issue) begin
          dp_q      <= 1'b1;
          dp_addr_q <= addr_q;
          addr_q    <= nxt_addr;
          a_cnt_q   <= a_cnt_q + BW'(1);
          restart_q <= 1'b0;
        end else begin
          dp_q      <= 1'b0;
          restart_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ahbm_shared_port_chk.sv
module ahbm_shared_port_chk #(
  parameter int AW         = 32,
  parameter int BOUND_LOG2 = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic [2:0]    hsize,
  input logic          hready,
  input logic [1:0]    hresp,
  input logic [1:0]    xfer_done,
  input logic [1:0]    rq_ready,
  input logic [1:0]    rd_valid,
  input logic [1:0]    wd_ready
);
  // R8
  never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans != 2'd1);
  // R3
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'd0) |-> (hsize <= 3'd2));
  // R4
  subword_nseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'd0 && hsize != 3'd2) |-> (htrans == 2'd2));
  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'd3 && $past(hready)) |-> (haddr == $past(haddr) + AW'(4)));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'd0 && !hready && hresp == 2'd0) |=> ($stable(haddr) && $stable(hsize)));
  // R7
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'd3) |-> (haddr[BOUND_LOG2-1:0] != '0));
  // R10
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp != 2'd0) |-> (htrans == 2'd0));
  // R12
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_done));
  // R1
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rq_ready));
  // R11
  rdwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|rd_valid) && (|wd_ready)));
endmodule

bind ahbm_shared_port ahbm_shared_port_chk #(.AW(AW), .BOUND_LOG2(BOUND_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .htrans    (htrans),
  .haddr     (haddr),
  .hsize     (hsize),
  .hready    (hready),
  .hresp     (hresp),
  .xfer_done (xfer_done),
  .rq_ready  (rq_ready),
  .rd_valid  (rd_valid),
  .wd_ready  (wd_ready)
);

// File: tb/ahbm_shared_port_tb.sv
`timescale 1ns/1ps
module ahbm_shared_port_tb;
  localparam int AW = 32, DW = 32, BW = 8;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  tr;
    logic [2:0]  sz;
    logic        wr;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]      rq_valid = '0, rq_ready, wd_ready, rd_valid, xfer_done;
  logic [AW-1:0]   c_addr [2];
  logic [1:0]      c_size [2];
  logic [BW-1:0]   c_beats [2];
  logic [1:0]      rq_incr, rq_write;
  logic [DW-1:0]   rd_data, hrdata, hwdata;
  logic            xfer_err, hgrant, hready, hbusreq, hwrite;
  logic [1:0]      hresp, htrans;
  logic [AW-1:0]   haddr;
  logic [2:0]      hsize;
  int              wcnt [2];

  function automatic logic [31:0] wpat(int who, int n);
    return 32'hC0DE_0000 + (who << 12) + n;
  endfunction
  function automatic logic [31:0] rdat(logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  ahbm_shared_port u_dut (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_addr({c_addr[1], c_addr[0]}), .rq_size({c_size[1], c_size[0]}),
    .rq_beats({c_beats[1], c_beats[0]}), .rq_incr(rq_incr), .rq_write(rq_write),
    .wd_data({wpat(1, wcnt[1]), wpat(0, wcnt[0])}), .wd_ready(wd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .hgrant(hgrant), .hready(hready), .hresp(hresp), .hrdata(hrdata),
    .hbusreq(hbusreq), .htrans(htrans), .haddr(haddr), .hsize(hsize),
    .hwrite(hwrite), .hwdata(hwdata)
  );

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard and slave model state
  beat_t exp_q[$];
  int    cur_who = 0, inj_seq = -1, acc_n = 0, dp_seq = 0, wait_n = 0, wcount = 0, grant_off = 0;
  logic [1:0]  inj_code = 2'd0, resp_code = 2'd0;
  bit          dp = 0, dp_wr = 0, resp2 = 0;
  logic [31:0] dp_addr = '0;
  bit          seen_rdy = 0, seen_done = 0;
  logic [1:0]  rdy_val = '0, done_val = '0;
  logic        err_val = 1'b0;

  // monitor: drives slave inputs at the falling edge, then observes
  initial begin
    hgrant = 1'b1; hready = 1'b1; hresp = 2'd0; hrdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        hgrant = (grant_off == 0);
        if (grant_off > 0) grant_off--;
        if (resp2) begin
          hready = 1'b1; hresp = resp_code;
        end else if (dp && dp_seq == inj_seq) begin
          hready = 1'b0; hresp = inj_code; resp_code = inj_code; resp2 = 1; inj_seq = -1;
        end else if (dp && wcount < wait_n) begin
          hready = 1'b0; hresp = 2'd0; wcount++;
        end else begin
          hready = 1'b1; hresp = 2'd0; hrdata = dp ? rdat(dp_addr) : '0;
        end
        #1;
        if (hresp != 2'd0) chk(htrans == 2'd0, "R10 idle during response", htrans, 0);
        if (dp && hready) begin
          if (hresp == 2'd0) begin
            if (dp_wr) begin
              chk(wd_ready == (2'b01 << cur_who), "R11 wd_ready", wd_ready, 2'b01 << cur_who);
              chk(hwdata == wpat(cur_who, wcnt[cur_who]), "R11 hwdata", hwdata, wpat(cur_who, wcnt[cur_who]));
              wcnt[cur_who]++;
            end else begin
              chk(rd_valid == (2'b01 << cur_who) && rd_data == rdat(dp_addr), "R11 read beat",
                  {rd_valid, rd_data}, {2'b01 << cur_who, rdat(dp_addr)});
            end
          end else begin
            chk(rd_valid == 0 && wd_ready == 0, hresp == 2'd1 ? "R10 no data on error" : "R9 no data on retry",
                {rd_valid, wd_ready}, 0);
            if (hresp == 2'd3) grant_off = 3;
            resp2 = 0;
          end
          dp = 0;
        end
        if (|xfer_done) begin seen_done = 1; done_val = xfer_done; err_val = xfer_err; end
        if (|rq_ready) begin seen_rdy = 1; rdy_val = rq_ready; end
        if (hready && htrans != 2'd0) begin
          if (exp_q.size() == 0) begin
            chk(0, "R10 unexpected beat", haddr, 0);
          end else begin
            beat_t e;
            beat_t a;
            e = exp_q.pop_front();
            a = '{addr: haddr, tr: htrans, sz: hsize, wr: hwrite};
            chk(a == e, "R4 R5 R6 R7 R9 beat order", a, e);
          end
          dp = 1; dp_addr = haddr; dp_wr = hwrite; dp_seq = acc_n; acc_n++; wcount = 0;
        end
      end
    end
  end

  // driver: pushes expected beats, raises the request, waits for the end
  task automatic xfer(logic [1:0] mask, int who, logic [31:0] addr, logic [1:0] sz, int beats,
                      bit incr, bit wr, int inj, logic [1:0] code, string tag);
    logic [1:0] esz;
    bit err;
    esz = (sz == 2'd3) ? 2'd2 : sz;
    err = (inj >= 0) && (code == 2'd1);
    for (int r = 0; r < 2; r++) begin
      if (mask[r]) begin
        c_addr[r] = addr; c_size[r] = sz; c_beats[r] = BW'(beats);
        rq_incr[r] = incr; rq_write[r] = wr;
      end
    end
    for (int i = 0; i < beats; i++) begin
      logic [31:0] a;
      a = incr ? addr + (i << esz) : addr;
      exp_q.push_back('{addr: a, tr: (i == 0 || !incr || esz != 2 || a[9:0] == 0) ? 2'd2 : 2'd3,
                        sz: {1'b0, esz}, wr: wr});
      if (i == inj) begin
        if (err) break;
        exp_q.push_back('{addr: a, tr: 2'd2, sz: {1'b0, esz}, wr: wr});
      end
    end
    cur_who = who; acc_n = 0; inj_seq = inj; inj_code = code;
    seen_rdy = 0; seen_done = 0;
    @(posedge clk); #1 rq_valid = mask;
    wait (seen_rdy);
    chk(rdy_val == (2'b01 << who), tag, rdy_val, 2'b01 << who);
    @(posedge clk); #1 rq_valid = '0;
    wait (seen_done);
    chk(done_val == (2'b01 << who) && err_val == err, err ? "R10 done with error" : "R12 done",
        {done_val, err_val}, {2'b01 << who, err});
    @(posedge clk); #1;
    chk(hbusreq == 0 && htrans == 0, "R12 quiet after done", {hbusreq, htrans}, 0);
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R9 all expected beats seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wcnt[0] = 0; wcnt[1] = 0;
    rq_incr = '0; rq_write = '0;
    for (int r = 0; r < 2; r++) begin c_addr[r] = '0; c_size[r] = '0; c_beats[r] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(htrans == 0 && hbusreq == 0 && rq_ready == 0 && rd_valid == 0 && wd_ready == 0 && xfer_done == 0,
        "R13 reset state", {htrans, hbusreq, rq_ready, xfer_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    xfer(2'b11, 1, 32'h100, 2'd2, 4, 1, 0, -1, 2'd0, "R2 receive first");
    xfer(2'b11, 1, 32'h200, 2'd2, 3, 1, 1, -1, 2'd0, "R1 owner wins again");
    xfer(2'b01, 0, 32'h301, 2'd0, 3, 1, 1, -1, 2'd0, "R2 other served, R4 byte");
    xfer(2'b11, 0, 32'h040, 2'd1, 3, 0, 0, -1, 2'd0, "R1 sticky transmit, R6 fixed half");
    xfer(2'b10, 1, 32'h3F8, 2'd2, 4, 1, 0, -1, 2'd0, "R7 line crossing");
    wait_n = 2;
    xfer(2'b01, 0, 32'h500, 2'd2, 3, 1, 1, -1, 2'd0, "R5 wait states");
    wait_n = 0;
    xfer(2'b01, 0, 32'h600, 2'd2, 4, 1, 1, 1, 2'd2, "R9 retry");
    xfer(2'b10, 1, 32'h700, 2'd2, 4, 1, 0, 2, 2'd3, "R9 split");
    xfer(2'b01, 0, 32'h800, 2'd2, 4, 1, 1, 1, 2'd1, "R10 error");
    xfer(2'b10, 1, 32'h900, 2'd3, 2, 1, 0, -1, 2'd0, "R3 size code 3");
    xfer(2'b11, 1, 32'hA00, 2'd2, 3, 0, 1, -1, 2'd0, "R6 fixed word");
    xfer(2'b10, 1, 32'hB02, 2'd1, 3, 1, 0, -1, 2'd0, "R4 halfword incr");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule